// File: doc/BRIEF.md
# Left Shift/Rotate Unit with Fill

This block is a purely combinational 4-bit left shifter. It moves a data word toward the high end by zero to three places. One control bit chooses the mode for the same datapath. In shift mode, every low-order place that the move empties takes the value of an external fill bit. In rotate mode, the bits pushed out at the top come back in at the bottom, and the fill bit plays no part.

The block has eight inputs: the mode bit, a 2-bit amount, the four data bits and the fill bit. It drives four outputs. The logic is a minimized two-level sum of products laid out as a programmable AND array feeding an OR array:

- The AND plane holds 19 distinct product terms.
- One of those terms serves two outputs, so the OR plane makes 20 connections.

The design has no clock, no reset and no state. In the house style, the nearest thing to a "state" is the pair of modes, shift and rotate. Changing the mode bit is the only "transition", and it takes effect in the same evaluation.

Top module: `shl_rot_fill`

## Requirements
- R1: When `i_amt` is 0, `o_data` equals `i_data` in both modes and for either value of `i_fill`.
- R2: With `i_rot`=0 and `i_amt`=k (an unsigned count, 0 to 3), every output bit j with j >= k equals `i_data[j-k]`.
- R3: With `i_rot`=0 and `i_amt`=k, every output bit j with j < k equals `i_fill`.
- R4: With `i_rot`=1 and `i_amt`=k, every output bit j equals `i_data[(j-k) mod 4]`, and `i_fill` has no effect on `o_data`.
- R5: In rotate mode, `o_data` holds the same number of ones as `i_data`.
- R6: When `i_amt` is 3, `o_data[3]` equals `i_data[0]` in both modes.
- R7: `o_data` is defined (no X) for all 256 combinations of the eight inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_rot | input | 1 | Mode select: 1 = rotate, 0 = shift with fill |
| i_amt | input | 2 | Left move amount, unsigned binary 0..3 |
| i_data | input | 4 | Data word |
| i_fill | input | 1 | Value loaded into emptied low bits in shift mode |
| o_data | output | 4 | Moved word |

## Verification
The bench drives all 256 input combinations, so every data pattern meets every amount in both modes with the fill bit at both levels.

- Pairs of vectors that differ only in the fill bit separate real fill loading from a hard-wired zero.
- In rotate mode, those same pairs show that the fill bit is ignored.
- Data words with a single one, or a single zero, expose any term wired to the wrong source bit or the wrong output.
- The zero-amount vectors confirm that both modes pass the word straight through.

// File: rtl/shl_rot_fill_pkg.sv
package shl_rot_fill_pkg;

    localparam int DATA_W    = 4;
    localparam int AMT_W     = 2;
    // literal vector: {rot, amt, data, fill}
    localparam int LIT_W     = 1 + AMT_W + DATA_W + 1;
    localparam int NUM_TERMS = 19;

    // literal bit positions inside the literal vector
    localparam int L_ROT  = LIT_W - 1;
    localparam int L_FILL = 0;

    // programming of one AND-plane row
    typedef struct packed {
        logic [LIT_W-1:0] pos;   // literal used uncomplemented
        logic [LIT_W-1:0] neg;   // literal used complemented
    } pla_row_t;

    // AND-plane programming; literal order R A1 A0 D3 D2 D1 D0 F
    function automatic pla_row_t pla_row(input int t);
        pla_row_t r;
        case (t)
            0:  r = '{pos: 8'h02, neg: 8'h60}; // A1'A0' D0
            1:  r = '{pos: 8'h21, neg: 8'h80}; // R' A0 F
            2:  r = '{pos: 8'h41, neg: 8'h80}; // R' A1 F   (shared)
            3:  r = '{pos: 8'hB0, neg: 8'h40}; // R A1'A0 D3
            4:  r = '{pos: 8'hC8, neg: 8'h20}; // R A1 A0' D2
            5:  r = '{pos: 8'hE4, neg: 8'h00}; // R A1 A0 D1
            6:  r = '{pos: 8'h04, neg: 8'h60}; // A1'A0' D1
            7:  r = '{pos: 8'h22, neg: 8'h40}; // A1'A0 D0
            8:  r = '{pos: 8'hD0, neg: 8'h20}; // R A1 A0' D3
            9:  r = '{pos: 8'hE8, neg: 8'h00}; // R A1 A0 D2
            10: r = '{pos: 8'h08, neg: 8'h60}; // A1'A0' D2
            11: r = '{pos: 8'h24, neg: 8'h40}; // A1'A0 D1
            12: r = '{pos: 8'h42, neg: 8'h20}; // A1 A0' D0
            13: r = '{pos: 8'h61, neg: 8'h80}; // R' A1 A0 F
            14: r = '{pos: 8'hF0, neg: 8'h00}; // R A1 A0 D3
            15: r = '{pos: 8'h10, neg: 8'h60}; // A1'A0' D3
            16: r = '{pos: 8'h28, neg: 8'h40}; // A1'A0 D2
            17: r = '{pos: 8'h44, neg: 8'h20}; // A1 A0' D1
            18: r = '{pos: 8'h62, neg: 8'h00}; // A1 A0 D0
            default: r = '{pos: '0, neg: '0};
        endcase
        return r;
    endfunction

    // OR-plane connections: which terms feed output o
    function automatic logic [NUM_TERMS-1:0] or_mask(input int o);
        logic [NUM_TERMS-1:0] m;
        case (o)
            0: m = 19'h0003F;   // terms 0..5
            1: m = 19'h003C4;   // terms 2,6,7,8,9
            2: m = 19'h07C00;   // terms 10..14
            3: m = 19'h78000;   // terms 15..18
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/shf_literal_pack.sv
module shf_literal_pack
    import shl_rot_fill_pkg::*;
(
    input  logic              rot,
    input  logic [AMT_W-1:0]  amt,
    input  logic [DATA_W-1:0] data,
    input  logic              fill,
    output logic [LIT_W-1:0]  lit
);

    assign lit = {rot, amt, data, fill};

endmodule

// File: rtl/shf_and_plane.sv
module shf_and_plane
    import shl_rot_fill_pkg::*;
(
    input  logic [LIT_W-1:0]     lit,
    output logic [NUM_TERMS-1:0] terms
);

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_row
        localparam pla_row_t ROW = pla_row(t);
        assign terms[t] = (&((~ROW.pos) | lit)) & (&((~ROW.neg) | ~lit));
    end

    // R4: in rotate mode no fill-driven term may fire
    always_comb begin
        if (!$isunknown(lit) && lit[L_ROT]) begin
            rot_nofill_chk: assert (terms[1] == 1'b0 && terms[2] == 1'b0 && terms[13] == 1'b0);
        end
    end

endmodule

// File: rtl/shf_or_plane.sv
module shf_or_plane
    import shl_rot_fill_pkg::*;
(
    input  logic [NUM_TERMS-1:0] terms,
    output logic [DATA_W-1:0]    y
);

    for (genvar o = 0; o < DATA_W; o++) begin : g_col
        localparam logic [NUM_TERMS-1:0] MASK = or_mask(o);
        assign y[o] = |(terms & MASK);
    end

    // R2: upper outputs draw from at most one active term each
    always_comb begin
        if (!$isunknown(terms)) begin
            term_excl_chk: assert ($onehot0(terms & or_mask(3)) && $onehot0(terms & or_mask(2)));
        end
    end

endmodule

// File: rtl/shl_rot_fill.sv
module shl_rot_fill
    import shl_rot_fill_pkg::*;
(
    input  logic              i_rot,
    input  logic [AMT_W-1:0]  i_amt,
    input  logic [DATA_W-1:0] i_data,
    input  logic              i_fill,
    output logic [DATA_W-1:0] o_data
);

    logic [LIT_W-1:0]     lit;
    logic [NUM_TERMS-1:0] terms;

    shf_literal_pack u_lit (
        .rot  (i_rot),
        .amt  (i_amt),
        .data (i_data),
        .fill (i_fill),
        .lit  (lit)
    );

    shf_and_plane u_and (
        .lit   (lit),
        .terms (terms)
    );

    shf_or_plane u_or (
        .terms (terms),
        .y     (o_data)
    );

    always_comb begin
        if (!$isunknown({i_rot, i_amt, i_data, i_fill})) begin
            // R7
            out_known_chk: assert (!$isunknown(o_data));
            // R1
            if (i_amt == '0) begin
                pass_thru_chk: assert (o_data == i_data);
            end
            // R5
            if (i_rot) begin
                rot_ones_chk: assert ($countones(o_data) == $countones(i_data));
            end
            // R6
            if (i_amt == AMT_W'(DATA_W - 1)) begin
                top_bit_chk: assert (o_data[DATA_W-1] == i_data[0]);
            end
            // R3
            if (!i_rot) begin
                for (int j = 0; j < DATA_W; j++) begin
                    if (j < int'(i_amt)) begin
                        vac_fill_chk: assert (o_data[j] == i_fill);
                    end
                end
            end
        end
    end

endmodule

// File: tb/shl_rot_fill_tb.sv
module shl_rot_fill_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       i_rot;
    logic [1:0] i_amt;
    logic [3:0] i_data;
    logic       i_fill;
    logic [3:0] o_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    shl_rot_fill u_dut (
        .i_rot  (i_rot),
        .i_amt  (i_amt),
        .i_data (i_data),
        .i_fill (i_fill),
        .o_data (o_data)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s rot=%0b amt=%0d data=%b fill=%0b: got %b expected %b",
                     req, i_rot, i_amt, i_data, i_fill, act, exp);
        end
    endtask

    initial begin
        i_rot = 0; i_amt = 0; i_data = 0; i_fill = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            {i_rot, i_amt, i_data, i_fill} = 8'(v);
            @(posedge clk);
            #1;
            begin
                int k;
                logic [3:0] exp_y;
                logic [3:0] hi_mask;
                logic [3:0] lo_mask;
                int ones;
                k = int'(i_amt);
                ones = 0;
                for (int j = 0; j < 4; j++) begin
                    int src;
                    src = j - k;
                    if (src >= 0) exp_y[j] = i_data[src];
                    else if (i_rot) exp_y[j] = i_data[src + 4];
                    else exp_y[j] = i_fill;
                    if (i_data[j]) ones++;
                end
                lo_mask = 4'((1 << k) - 1);
                hi_mask = ~lo_mask;
                // R7
                check("R7", 4'(($isunknown(o_data)) ? 1 : 0), 4'd0);
                if (k == 0) check("R1", o_data, i_data);
                if (!i_rot) begin
                    check("R2", o_data & hi_mask, exp_y & hi_mask);
                    check("R3", o_data & lo_mask, {4{i_fill}} & lo_mask);
                end else begin
                    check("R4", o_data, exp_y);
                    check("R5", 4'($countones(o_data)), 4'(ones));
                end
                if (k == 3) check("R6", {3'b0, o_data[3]}, {3'b0, i_data[0]});
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule